// File: doc/BRIEF.md
# Scatter-Gather DMA Write Engine

This block lives on the device side of a PCI Express endpoint and copies data from the device's own transmit buffer into host memory. Software gives it a list of (address, byte length) segments. The engine cuts each segment into posted memory-write requests and presents them on a request channel. Each request is one header beat (requester ID, target address, byte length) followed by its payload beats. Once the last data write has been accepted, the engine issues one message-signalled interrupt write. The interrupt write goes out on the same channel, so it cannot pass any earlier data write.

Three streams use valid/ready handshakes:
- the descriptor input,
- the source data input,
- the request output.

A beat transfers on a rising clock edge where valid and ready are both high. On each of these streams the engine never withdraws or changes a beat it has offered before that beat is accepted. It applies back-pressure to the source stream by driving `src_ready` from `req_ready`, so payload beats flow straight through with no buffering. The host address, the byte lengths and the maximum payload are all in bytes. Addresses and lengths handed to the engine are multiples of the 4-byte beat.

A 16-bit command register, written through `cmd_wr_en`/`cmd_wr_data`, holds the bus-master enable in bit 2. No memory request may start while that bit is 0. The maximum payload setting, requester ID and interrupt address/data are plain inputs, held steady while the engine is busy.

Top module: `dmaw_engine`

## Requirements
- R1: The command register resets to 0 and its bit 2 is the bus-master enable. While that bit is 0 no new request header is offered. A transfer that reaches a request boundary in that state stops with `err`=1 and `done`=0.
- R2: `mps_sel` encodes the maximum payload: 0→128, 1→256, 2→512, 3→128 bytes. No data request carries more bytes than this, and none carries 0 bytes.
- R3: No data request crosses a 4096-byte address boundary. A segment that would cross one is split exactly at the boundary.
- R4: A segment is sent as requests in ascending address order, each chunk taking the largest size R2 and R3 allow. Each header beat has `req_sop`=1 and carries `requester_id`, the target address and the byte length. Length/4 payload beats follow, with `req_eop` on the last one. The payload carries the source stream's words in arrival order.
- R5: An offered header stays valid with unchanged address, length and type until accepted. A payload beat is offered exactly when `src_valid` is high, and a source word is consumed only when `req_ready` is high.
- R6: A descriptor whose length is 0 is consumed and produces no request.
- R7: After the last payload beat of a transfer is accepted, the engine sends one interrupt write: a header with `req_irq`=1, address `irq_addr` and length 4, then one beat with data `irq_data` and `req_eop`=1. A transfer started with `desc_count`=0 sends only this write.
- R8: If bus-master enable is cleared during a transfer, the request in progress completes. No further header is started and no interrupt write is sent, and the engine returns to idle with `err`=1.
- R9: `busy` is high from the cycle after an accepted `start` until the transfer ends. `done` is set only by a completed interrupt write, and `done` and `err` are cleared by the next accepted start. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_en | input | 1 | Write strobe for the command register |
| cmd_wr_data | input | 16 | Command register value; bit 2 is bus-master enable |
| mps_sel | input | 2 | Maximum payload select (see R2) |
| requester_id | input | 16 | Bus/device/function number placed in headers |
| irq_addr | input | 32 | Interrupt write address |
| irq_data | input | 32 | Interrupt write data |
| start | input | 1 | Start pulse, accepted only while idle |
| desc_count | input | 4 | Number of descriptors in the list |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Engine accepts a descriptor |
| desc_addr | input | 32 | Segment start address in host memory |
| desc_len | input | 16 | Segment length in bytes |
| src_valid | input | 1 | Source data word offered |
| src_ready | output | 1 | Engine consumes the source word |
| src_data | input | 32 | Source data word |
| req_valid | output | 1 | Request beat offered |
| req_ready | input | 1 | Channel accepts the beat |
| req_sop | output | 1 | Beat is a header |
| req_eop | output | 1 | Last payload beat of the request |
| req_irq | output | 1 | Beat belongs to the interrupt write |
| req_rid | output | 16 | Requester ID |
| req_addr | output | 32 | Target address (header beats) |
| req_len | output | 16 | Request byte length (header beats) |
| req_data | output | 32 | Payload word (payload beats) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer ended with its interrupt write |
| err | output | 1 | Last transfer was stopped by bus-master enable |

## Verification
The bench targets these cases:
- A segment starting 128 bytes or 16 bytes below a 4 KB page end. An engine that splits only by payload size would emit a request crossing the page.
- A zero-length descriptor in the middle of a list. A careless engine would emit an empty header or stall waiting for data.
- An empty list. The interrupt write must still appear.

Random back-pressure on both the source and request channels catches a header that changes or drops while waiting, and payload words that are lost or repeated.

Three sequences check the status and enable handling:
- Starting with the enable still at its reset value must end in error with no request at all.
- Clearing the enable mid-list must let the current request finish, then stop without an interrupt. An engine that cut off mid-payload, or that kept going, shows up as a mismatched or extra beat.
- A second start pulse during a transfer must neither restart the list nor consume descriptors.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_HDR,
    ST_DATA,
    ST_IRQ_HDR,
    ST_IRQ_DAT
  } dmaw_state_e;

  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned MPS_BASE  = 128;

endpackage

// File: rtl/dmaw_cmd_reg.sv
module dmaw_cmd_reg #(
  parameter int unsigned CMD_W   = 16,
  parameter int unsigned BME_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  output logic             bme
);
  logic [CMD_W-1:0] cmd_q;
  logic             cmd_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmd_q <= '0;
    else if (wr_en) cmd_q <= wr_data;
  end

  assign bme        = cmd_q[BME_BIT];
  assign cmd_unused = ^{cmd_q[CMD_W-1:BME_BIT+1], cmd_q[BME_BIT-1:0]};

endmodule

// File: rtl/dmaw_chunk_calc.sv
module dmaw_chunk_calc
  import dmaw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remain,
  input  logic [1:0]        mps_sel,
  output logic [LEN_W-1:0]  chunk
);
  localparam int unsigned PAGE = 1 << PAGE_BITS;

  logic [LEN_W-1:0] mps;
  logic [LEN_W-1:0] room;

  always_comb begin
    unique case (mps_sel)
      2'd1:    mps = LEN_W'(2 * MPS_BASE);
      2'd2:    mps = LEN_W'(4 * MPS_BASE);
      default: mps = LEN_W'(MPS_BASE);
    endcase
    room  = LEN_W'(PAGE) - LEN_W'(addr[PAGE_BITS-1:0]);
    chunk = remain;
    if (mps < chunk)  chunk = mps;
    if (room < chunk) chunk = room;
  end

endmodule

// File: rtl/dmaw_engine.sv
module dmaw_engine
  import dmaw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned RID_W  = 16,
  parameter int unsigned CMD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_en,
  input  logic [CMD_W-1:0]  cmd_wr_data,
  input  logic [1:0]        mps_sel,
  input  logic [RID_W-1:0]  requester_id,
  input  logic [ADDR_W-1:0] irq_addr,
  input  logic [DATA_W-1:0] irq_data,
  input  logic              start,
  input  logic [CNT_W-1:0]  desc_count,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_sop,
  output logic              req_eop,
  output logic              req_irq,
  output logic [RID_W-1:0]  req_rid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int unsigned BEAT_BYTES = DATA_W / 8;
  localparam int unsigned BEAT_SHIFT = $clog2(BEAT_BYTES);
  localparam int unsigned PAGE       = 1 << PAGE_BITS;

  dmaw_state_e       state;
  logic              bme;
  logic              hdr_live;
  logic              go_hdr;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  seg_left;
  logic [LEN_W-1:0]  beat_left;
  logic [CNT_W-1:0]  desc_left;
  logic [LEN_W-1:0]  chunk;

  dmaw_cmd_reg #(.CMD_W(CMD_W), .BME_BIT(2)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr_en), .wr_data(cmd_wr_data), .bme(bme)
  );

  dmaw_chunk_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chunk (
    .addr(cur_addr), .remain(seg_left), .mps_sel(mps_sel), .chunk(chunk)
  );

  // A header already on offer is kept; a new one needs the enable.
  assign go_hdr = hdr_live || bme;
  assign busy   = (state != ST_IDLE);

  always_comb begin
    desc_ready = 1'b0;
    src_ready  = 1'b0;
    req_valid  = 1'b0;
    req_sop    = 1'b0;
    req_eop    = 1'b0;
    req_irq    = 1'b0;
    req_rid    = requester_id;
    req_addr   = cur_addr;
    req_len    = chunk;
    req_data   = src_data;
    unique case (state)
      ST_FETCH: desc_ready = 1'b1;
      ST_HDR: begin
        req_valid = go_hdr;
        req_sop   = 1'b1;
      end
      ST_DATA: begin
        req_valid = src_valid;
        src_ready = req_ready;
        req_eop   = (beat_left == LEN_W'(1));
      end
      ST_IRQ_HDR: begin
        req_valid = go_hdr;
        req_sop   = 1'b1;
        req_irq   = 1'b1;
        req_addr  = irq_addr;
        req_len   = LEN_W'(BEAT_BYTES);
      end
      ST_IRQ_DAT: begin
        req_valid = 1'b1;
        req_irq   = 1'b1;
        req_eop   = 1'b1;
        req_data  = irq_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hdr_live  <= 1'b0;
      cur_addr  <= '0;
      seg_left  <= '0;
      beat_left <= '0;
      desc_left <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      hdr_live <= ((state == ST_HDR) || (state == ST_IRQ_HDR)) && req_valid && !req_ready;
      unique case (state)
        ST_IDLE: if (start) begin
          done      <= 1'b0;
          err       <= 1'b0;
          desc_left <= desc_count;
          state     <= (desc_count == '0) ? ST_IRQ_HDR : ST_FETCH;
        end
        ST_FETCH: if (desc_valid) begin
          desc_left <= desc_left - CNT_W'(1);
          if (desc_len == '0) begin
            state <= (desc_left == CNT_W'(1)) ? ST_IRQ_HDR : ST_FETCH;
          end else begin
            cur_addr <= desc_addr;
            seg_left <= desc_len;
            state    <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (!go_hdr) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else if (req_ready) begin
            beat_left <= chunk >> BEAT_SHIFT;
            cur_addr  <= cur_addr + ADDR_W'(chunk);
            seg_left  <= seg_left - chunk;
            state     <= ST_DATA;
          end
        end
        ST_DATA: if (src_valid && req_ready) begin
          beat_left <= beat_left - LEN_W'(1);
          if (beat_left == LEN_W'(1)) begin
            if (seg_left != '0)       state <= ST_HDR;
            else if (desc_left != '0) state <= ST_FETCH;
            else                      state <= ST_IRQ_HDR;
          end
        end
        ST_IRQ_HDR: begin
          if (!go_hdr) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else if (req_ready) begin
            state <= ST_IRQ_DAT;
          end
        end
        ST_IRQ_DAT: if (req_ready) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [LEN_W-1:0] mps_lim;
  assign mps_lim = LEN_W'(MPS_BASE) << ((mps_sel == 2'd3) ? 2'd0 : mps_sel);

  assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sop && !$past(req_valid && req_sop && !req_ready)) |-> bme);

  assert_mps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sop && !req_irq) |-> (req_len != '0 && req_len <= mps_lim));

  assert_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sop && !req_irq) |->
      ((32'(req_addr[PAGE_BITS-1:0]) + 32'(req_len)) <= 32'(PAGE)));

  assert_hdr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sop && !req_ready) |=>
      (req_valid && req_sop && $stable(req_addr) && $stable(req_len) && $stable(req_irq)));

  assert_src_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |-> (req_valid && req_ready && !req_sop));

  assert_irq_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_irq && !req_sop) |-> (req_eop && !src_ready));

  assert_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done) && !(done && err));

endmodule

// File: tb/dmaw_engine_bench.sv
module dmaw_engine_bench;
  localparam int AW = 32, DW = 32, LW = 16, CW = 4;
  localparam logic [15:0] RID   = 16'h0A28;
  localparam logic [31:0] IADDR = 32'hFEE0_1000;
  localparam logic [31:0] IDATA = 32'h0000_4071;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr_en = 1'b0;
  logic [15:0] cmd_wr_data = '0;
  logic [1:0] mps_sel = 2'd0;
  logic start = 1'b0;
  logic [CW-1:0] desc_count = '0;
  logic desc_valid = 1'b0, desc_ready;
  logic [AW-1:0] desc_addr = '0;
  logic [LW-1:0] desc_len = '0;
  logic src_valid = 1'b0, src_ready;
  logic [DW-1:0] src_data = '0;
  logic req_valid, req_ready = 1'b0, req_sop, req_eop, req_irq;
  logic [15:0] req_rid;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic [DW-1:0] req_data;
  logic busy, done, err;

  always #10 clk = ~clk;

  dmaw_engine u_dmaw_engine (
    .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .mps_sel(mps_sel), .requester_id(RID), .irq_addr(IADDR), .irq_data(IDATA),
    .start(start), .desc_count(desc_count), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_addr(desc_addr), .desc_len(desc_len),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_sop(req_sop),
    .req_eop(req_eop), .req_irq(req_irq), .req_rid(req_rid), .req_addr(req_addr),
    .req_len(req_len), .req_data(req_data), .busy(busy), .done(done), .err(err)
  );

  int checks = 0, errors = 0;
  string cur_req = "R4";
  int unsigned src_cnt = 32'h100;
  bit bme_off = 1'b0;
  int new_hdr_after_off = 0, irq_seen = 0;
  bit prev_hdr_pending = 1'b0;

  logic [AW-1:0] dq_addr[$];
  logic [LW-1:0] dq_len[$];
  logic          e_sop[$], e_eop[$], e_irq[$];
  logic [AW-1:0] e_addr[$];
  logic [LW-1:0] e_len[$];
  logic [DW-1:0] e_dat[$];
  logic [AW-1:0] ta[$];
  int            tl[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int mps_of(input logic [1:0] s);
    return (s == 2'd1) ? 256 : (s == 2'd2) ? 512 : 128;
  endfunction

  // Reference model: expected beat sequence for the queued segment list.
  task automatic expect_transfer();
    int unsigned k = src_cnt;
    for (int i = 0; i < ta.size(); i++) begin
      int a = int'(ta[i]);
      int rem = tl[i];
      dq_addr.push_back(ta[i]);
      dq_len.push_back(LW'(tl[i]));
      while (rem > 0) begin
        int c = rem;
        if (mps_of(mps_sel) < c) c = mps_of(mps_sel);
        if (4096 - (a % 4096) < c) c = 4096 - (a % 4096);
        e_sop.push_back(1); e_eop.push_back(0); e_irq.push_back(0);
        e_addr.push_back(AW'(a)); e_len.push_back(LW'(c)); e_dat.push_back('0);
        for (int b = 0; b < c / 4; b++) begin
          e_sop.push_back(0); e_eop.push_back(b == c / 4 - 1); e_irq.push_back(0);
          e_addr.push_back('0); e_len.push_back('0); e_dat.push_back(DW'(k));
          k++;
        end
        a += c;
        rem -= c;
      end
    end
    e_sop.push_back(1); e_eop.push_back(0); e_irq.push_back(1);
    e_addr.push_back(IADDR); e_len.push_back(LW'(4)); e_dat.push_back('0);
    e_sop.push_back(0); e_eop.push_back(1); e_irq.push_back(1);
    e_addr.push_back('0); e_len.push_back('0); e_dat.push_back(IDATA);
    ta.delete();
    tl.delete();
  endtask

  task automatic flush_expect();
    e_sop.delete(); e_eop.delete(); e_irq.delete();
    e_addr.delete(); e_len.delete(); e_dat.delete();
    dq_addr.delete(); dq_len.delete();
  endtask

  // Stream driver and per-cycle monitor, both away from the rising edge.
  always @(negedge clk) begin
    req_ready  = ($urandom % 4) != 0;
    src_valid  = ($urandom % 5) != 0;
    src_data   = DW'(src_cnt);
    desc_valid = dq_addr.size() > 0;
    desc_addr  = desc_valid ? dq_addr[0] : '0;
    desc_len   = desc_valid ? dq_len[0] : '0;
    #1;
    if (rst_n) begin
      if (desc_valid && desc_ready) begin
        void'(dq_addr.pop_front());
        void'(dq_len.pop_front());
      end
      if (src_valid && src_ready) src_cnt++;
      if (req_valid && req_sop && !prev_hdr_pending && bme_off) new_hdr_after_off++;
      prev_hdr_pending = req_valid && req_sop && !req_ready;
      if (req_valid && req_ready) begin
        if (req_irq && req_sop) irq_seen++;
        if (e_sop.size() == 0) begin
          check(0, cur_req, "unexpected request beat addr", req_addr, 0);
        end else begin
          check(req_sop == e_sop[0], "R4", "sop flag", req_sop, e_sop[0]);
          check(req_irq == e_irq[0], "R7", "irq flag", req_irq, e_irq[0]);
          if (e_sop[0]) begin
            check(req_addr == e_addr[0], cur_req, "header address", req_addr, e_addr[0]);
            check(req_len == e_len[0], cur_req, "header length", req_len, e_len[0]);
            check(req_rid == RID, "R4", "requester id", req_rid, RID);
          end else begin
            check(req_data == e_dat[0], "R4", "payload word", req_data, e_dat[0]);
            check(req_eop == e_eop[0], "R4", "eop flag", req_eop, e_eop[0]);
          end
          void'(e_sop.pop_front()); void'(e_eop.pop_front()); void'(e_irq.pop_front());
          void'(e_addr.pop_front()); void'(e_len.pop_front()); void'(e_dat.pop_front());
        end
      end
    end
  end

  task automatic write_cmd(input logic [15:0] v);
    @(negedge clk); cmd_wr_en = 1'b1; cmd_wr_data = v;
    @(negedge clk); cmd_wr_en = 1'b0;
  endtask

  task automatic pulse_start(input int n);
    @(negedge clk); start = 1'b1; desc_count = CW'(n);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    #3;
  endtask

  task automatic run(input string req, input int n);
    cur_req = req;
    expect_transfer();
    pulse_start(n);
    wait_idle();
    check(e_sop.size() == 0, req, "expected beats left", e_sop.size(), 0);
    check(done == 1'b1 && err == 1'b0, "R9", "done/err after transfer", {done, err}, 2'b10);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    check(busy == 0 && done == 0 && err == 0, "R9", "reset status", {busy, done, err}, 0);
    check(req_valid == 0 && desc_ready == 0, "R1", "reset outputs idle", req_valid, 0);

    // R1: enable still at reset value, so no request leaves and the run ends in error
    cur_req = "R1";
    dq_addr.push_back(32'h1000); dq_len.push_back(16'd64);
    pulse_start(1);
    wait_idle();
    check(err == 1 && done == 0, "R1", "error with bus-master off", {err, done}, 2'b10);

    write_cmd(16'h0004);
    mps_sel = 2'd0;  // R2: 300 bytes at 128 -> 128,128,44
    ta.push_back(32'h2000); tl.push_back(300);
    run("R2", 1);

    mps_sel = 2'd2;  // R3: 128 to the page end, then 384
    ta.push_back(32'h1F80); tl.push_back(512);
    run("R3", 1);

    mps_sel = 2'd1;  // R6: zero-length descriptor in the middle
    ta.push_back(32'h3000); tl.push_back(40);
    ta.push_back(32'h5000); tl.push_back(0);
    ta.push_back(32'h6100); tl.push_back(260);
    run("R6", 3);
    check(dq_addr.size() == 0, "R6", "all descriptors consumed", dq_addr.size(), 0);

    irq_seen = 0;    // R7: empty list still interrupts
    run("R7", 0);
    check(irq_seen == 1, "R7", "interrupt writes for empty list", irq_seen, 1);

    mps_sel = 2'd3;  // R2/R3: select 3 behaves as 128, split 16 then 32 at the page
    ta.push_back(32'h7FF0); tl.push_back(48);
    run("R3", 1);

    // R9: start while busy is ignored
    mps_sel = 2'd2;
    cur_req = "R9";
    ta.push_back(32'h8000); tl.push_back(1024);
    expect_transfer();
    pulse_start(1);
    repeat (10) @(negedge clk);
    check(busy == 1, "R9", "busy during transfer", busy, 1);
    start = 1'b1; desc_count = CW'(1);
    @(negedge clk); start = 1'b0;
    wait_idle();
    check(e_sop.size() == 0 && done == 1, "R9", "single run despite extra start", e_sop.size(), 0);
    repeat (20) @(negedge clk);
    #3;
    check(busy == 0, "R9", "no restart after ignored start", busy, 0);

    // R8: clear bus-master enable in the middle of a long list
    mps_sel = 2'd0;
    cur_req = "R8";
    irq_seen = 0;
    ta.push_back(32'h9000); tl.push_back(2048);
    expect_transfer();
    pulse_start(1);
    repeat (30) @(negedge clk);
    cmd_wr_en = 1'b1; cmd_wr_data = 16'h0000;
    @(negedge clk); cmd_wr_en = 1'b0; bme_off = 1'b1;
    wait_idle();
    check(err == 1 && done == 0, "R8", "error after enable cleared", {err, done}, 2'b10);
    check(irq_seen == 0, "R8", "no interrupt after abort", irq_seen, 0);
    check(new_hdr_after_off == 0, "R8", "new headers after clear", new_hdr_after_off, 0);
    check(e_sop.size() > 0, "R8", "transfer cut short", e_sop.size(), 1);
    check(prev_hdr_pending == 0, "R8", "no header left pending", prev_hdr_pending, 0);
    flush_expect();
    bme_off = 1'b0;

    // R9/R1: re-enable, a new start clears the error
    write_cmd(16'h0004);
    ta.push_back(32'hA000); tl.push_back(8);
    run("R9", 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule